// File: doc/BRIEF.md
# Completion Timeout Record Queue

This block collects one record for each non-posted request whose completion never arrived and holds those records in order until software has dealt with them. An upstream transaction tracker pushes a record in a single cycle. The record carries the requesting function's identity, which is the physical function number, the virtual function number and a flag that marks the virtual function as active. It also carries the number of bytes still owed, the request tag, the traffic class and two ordering attribute bits.

Software sees the oldest record through a byte-wide register window. It reads the fields of that record, then writes a pop command so that the next record moves up. A level interrupt stays high for as long as any record is waiting. A sticky overflow output reports that at least one record was lost because the queue was full.

Top module: `cto_record_queue`

## Requirements
- R1: After reset the queue is empty: the status byte reads 0x01, `irq` is 0 and `overflow` is 0.
- R2: `irq` is 1 exactly while the queue holds at least one record. It reads 0 in the cycle after the pop that removes the last record.
- R3: Offset 0 is the status byte. Bit 0 reads 1 when the queue is empty. Bit 1 reads 1 when it holds DEPTH records (16 by default). Bits 7:2 read 0.
- R4: Offset 1 is the pop command. A write with data bit 0 set removes the head record. A write with bit 0 clear changes nothing. A read of offset 1 returns 0.
- R5: Offset 2 returns VF number bits 7:0. Offset 3 returns {vf_active, 0, pf[2:0], vf[10:8]}, with bit 7 as the most significant bit.
- R6: Offset 4 returns bits 7:0 of the 12-bit remaining byte count. Offset 5 returns {4'b0, count[11:8]}.
- R7: Offset 6 returns tag bits 7:0. Offset 7 returns {tc[2:0], relaxed_ordering, no_snoop, 0, tag[9:8]}.
- R8: Records leave in the order they were pushed. The head fields read the same values on every read until a pop is written.
- R9: A push that arrives while the queue is full, with no pop in the same cycle, is dropped and sets `overflow`. Only reset clears `overflow`.
- R10: A pop written while the queue is empty is ignored. While the queue is empty, offsets 2 to 7 read 0.
- R11: A push and a pop in the same cycle are both accepted when the queue is not empty, and the occupancy stays the same. This holds even when the queue is full. On an empty queue the pop is ignored and the push is kept.
- R12: `rd_data` and `rd_valid` are valid in the cycle after `rd_en`. A read always returns the state from before any pop issued in that same cycle. Offsets 8 to 15 read 0. Writes to any offset other than 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_en | input | 1 | Push one record this cycle |
| push_vf | input | 11 | Virtual function number |
| push_pf | input | 3 | Physical function number |
| push_vf_act | input | 1 | Virtual function active flag |
| push_len | input | 12 | Remaining byte count |
| push_tag | input | 10 | Request tag |
| push_tc | input | 3 | Traffic class |
| push_ro | input | 1 | Relaxed ordering attribute |
| push_ns | input | 1 | No-snoop attribute |
| rd_en | input | 1 | Register read request |
| wr_en | input | 1 | Register write request |
| addr | input | 4 | Byte offset in the window |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, one cycle after `rd_en` |
| rd_valid | output | 1 | Marks `rd_data` as valid |
| irq | output | 1 | Records waiting |
| overflow | output | 1 | Sticky flag: a record was lost |

## Verification
A corrupted pointer or occupancy count shows up at the ports within a few cycles. `irq` or the status flags disagree with the number of pushes and pops, or the head fields return a record that is stale, repeated or skipped on the very next read. The bench keeps an ordered list of expected records and compares `irq` and `overflow` after every clock edge. It also compares every read result in the cycle it returns. Field packing errors therefore appear on the first read of the wrong byte, and a missed or extra pop appears on the first read after it.

// File: rtl/cto_pkg.sv
package cto_pkg;
    localparam int VF_W  = 11;
    localparam int PF_W  = 3;
    localparam int LEN_W = 12;
    localparam int TAG_W = 10;
    localparam int TC_W  = 3;
    localparam int BYTE_W = 8;
    localparam int WIN_REGS = 8;

    // register offsets; the read mux decodes these
    localparam int OFS_STAT  = 0;
    localparam int OFS_POP   = 1;
    localparam int OFS_VFLO  = 2;
    localparam int OFS_FUNC  = 3;
    localparam int OFS_LENLO = 4;
    localparam int OFS_LENHI = 5;
    localparam int OFS_TAGLO = 6;
    localparam int OFS_TAGHI = 7;

    typedef struct packed {
        logic [VF_W-1:0]  vf;
        logic [PF_W-1:0]  pf;
        logic             vf_act;
        logic [LEN_W-1:0] len;
        logic [TAG_W-1:0] tag;
        logic [TC_W-1:0]  tc;
        logic             ro;
        logic             ns;
    } cto_rec_t;
endpackage

// File: rtl/cto_rec_store.sv
module cto_rec_store
    import cto_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push_i,
    input  cto_rec_t rec_i,
    input  logic     pop_i,
    output cto_rec_t head_o,
    output logic     empty_o,
    output logic     full_o,
    output logic     ovf_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
        logic             ovf;
    } st_t;

    st_t      st_d, st_q;
    logic     pop_ok, push_ok;
    cto_rec_t mem_q [DEPTH];

    always_comb begin
        st_d    = st_q;
        pop_ok  = pop_i && (st_q.count != '0);
        push_ok = push_i && ((st_q.count != FULL_CNT) || pop_ok);
        if (push_ok) begin
            st_d.wr_ptr = (st_q.wr_ptr == LAST_IDX) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (pop_ok) begin
            st_d.rd_ptr = (st_q.rd_ptr == LAST_IDX) ? '0 : st_q.rd_ptr + 1'b1;
        end
        if (push_ok && !pop_ok) begin
            st_d.count = st_q.count + 1'b1;
        end else if (pop_ok && !push_ok) begin
            st_d.count = st_q.count - 1'b1;
        end
        if (push_i && !push_ok) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem_q[st_q.wr_ptr] <= rec_i;
        end
    end

    assign empty_o = (st_q.count == '0);
    assign full_o  = (st_q.count == FULL_CNT);
    assign ovf_o   = st_q.ovf;
    assign head_o  = empty_o ? '0 : mem_q[st_q.rd_ptr];

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= FULL_CNT);
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> (st_q.count == FULL_CNT) && ovf_o);
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);
    p_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !push_i) |=> empty_o);
    p_push_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !empty_o) |=> $stable(st_q.count));
    p_head_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop_i && !empty_o) |=> $stable(head_o));
    p_empty_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> (head_o == '0));
endmodule

// File: rtl/cto_reg_port.sv
module cto_reg_port
    import cto_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  cto_rec_t          head_i,
    input  logic              empty_i,
    input  logic              full_i,
    output logic              pop_o,
    output logic [BYTE_W-1:0] rdata_o,
    output logic              rvalid_o
);
    localparam int SEL_W = $clog2(WIN_REGS);
    localparam logic [ADDR_W-1:0] WIN_END = ADDR_W'(WIN_REGS);

    typedef struct packed {
        logic [BYTE_W-1:0] rdata;
        logic              rvalid;
    } st_t;

    st_t               st_d, st_q;
    logic [BYTE_W-1:0] win [WIN_REGS];

    always_comb begin
        win[OFS_STAT]  = {6'b0, full_i, empty_i};
        win[OFS_POP]   = '0;
        win[OFS_VFLO]  = head_i.vf[7:0];
        win[OFS_FUNC]  = {head_i.vf_act, 1'b0, head_i.pf, head_i.vf[10:8]};
        win[OFS_LENLO] = head_i.len[7:0];
        win[OFS_LENHI] = {4'b0, head_i.len[11:8]};
        win[OFS_TAGLO] = head_i.tag[7:0];
        win[OFS_TAGHI] = {head_i.tc, head_i.ro, head_i.ns, 1'b0, head_i.tag[9:8]};
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = rd_i;
        if (rd_i) begin
            st_d.rdata = (addr_i < WIN_END) ? win[addr_i[SEL_W-1:0]] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pop_o    = wr_i && (addr_i == ADDR_W'(OFS_POP)) && wdata_i[0];
    assign rdata_o  = st_q.rdata;
    assign rvalid_o = st_q.rvalid;

    p_rvalid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> rvalid_o);
    p_no_rvalid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> !rvalid_o);
    p_unmapped_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && (addr_i >= WIN_END)) |=> (rdata_o == '0));
    p_stat_rsvd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && (addr_i == ADDR_W'(OFS_STAT))) |=> (rdata_o[7:2] == '0));
    p_pop_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && (addr_i == ADDR_W'(OFS_POP))) |=> (rdata_o == '0));
endmodule

// File: rtl/cto_record_queue.sv
module cto_record_queue
    import cto_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [VF_W-1:0]   push_vf,
    input  logic [PF_W-1:0]   push_pf,
    input  logic              push_vf_act,
    input  logic [LEN_W-1:0]  push_len,
    input  logic [TAG_W-1:0]  push_tag,
    input  logic [TC_W-1:0]   push_tc,
    input  logic              push_ro,
    input  logic              push_ns,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              irq,
    output logic              overflow
);
    cto_rec_t rec_in, head;
    logic     pop, empty, full;

    assign rec_in = '{vf: push_vf, pf: push_pf, vf_act: push_vf_act, len: push_len,
                      tag: push_tag, tc: push_tc, ro: push_ro, ns: push_ns};

    cto_rec_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (push_en),
        .rec_i  (rec_in),
        .pop_i  (pop),
        .head_o (head),
        .empty_o(empty),
        .full_o (full),
        .ovf_o  (overflow)
    );

    cto_reg_port #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_i    (rd_en),
        .wr_i    (wr_en),
        .addr_i  (addr),
        .wdata_i (wr_data),
        .head_i  (head),
        .empty_i (empty),
        .full_i  (full),
        .pop_o   (pop),
        .rdata_o (rd_data),
        .rvalid_o(rd_valid)
    );

    assign irq = !empty;

    p_irq_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !push_en && !wr_en) |=> irq);
    p_irq_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |=> irq);
endmodule

// File: tb/cto_record_queue_tb.sv
module cto_record_queue_tb;
    localparam int CLK_PERIOD = 10;
    localparam int QDEPTH = 16;

    typedef struct packed {
        logic [10:0] vf;
        logic [2:0]  pf;
        logic        act;
        logic [11:0] len;
        logic [9:0]  tag;
        logic [2:0]  tc;
        logic        ro;
        logic        ns;
    } ref_rec_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_en = 1'b0;
    ref_rec_t   pr = '0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       rd_valid, irq, overflow;

    int total = 0;
    int bad = 0;
    int seq = 0;
    ref_rec_t model[$];
    bit       m_ovf = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cto_record_queue u_dut (
        .clk(clk), .rst_n(rst_n), .push_en(push_en),
        .push_vf(pr.vf), .push_pf(pr.pf), .push_vf_act(pr.act), .push_len(pr.len),
        .push_tag(pr.tag), .push_tc(pr.tc), .push_ro(pr.ro), .push_ns(pr.ns),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .rd_valid(rd_valid), .irq(irq), .overflow(overflow)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic ref_rec_t mk(int n);
        ref_rec_t r;
        r.vf  = 11'(n * 173 + 5);
        r.pf  = 3'(n * 3 + 1);
        r.act = n[0];
        r.len = 12'(n * 611 + 9);
        r.tag = 10'(n * 97 + 3);
        r.tc  = 3'(n * 5 + 2);
        r.ro  = n[1];
        r.ns  = ~n[2];
        return r;
    endfunction

    function automatic logic [7:0] exp_byte(int a);
        ref_rec_t h = (model.size() != 0) ? model[0] : '0;
        case (a)
            0: return {6'b0, model.size() == QDEPTH, model.size() == 0};
            2: return h.vf[7:0];
            3: return {h.act, 1'b0, h.pf, h.vf[10:8]};
            4: return h.len[7:0];
            5: return {4'b0, h.len[11:8]};
            6: return h.tag[7:0];
            7: return {h.tc, h.ro, h.ns, 1'b0, h.tag[9:8]};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(int a);
        case (a)
            0: return "R3";
            1: return "R4";
            2, 3: return "R5";
            4, 5: return "R6";
            6, 7: return "R7";
            default: return "R12";
        endcase
    endfunction

    // one clock: drive, advance model on the edge, compare just after it
    task automatic step(bit p, bit rd, bit wr, int a, logic [7:0] wd, string why);
        logic [7:0] e;
        bit pop_req, push_ok;
        push_en = p;
        if (p) begin
            pr = mk(seq);
        end
        rd_en = rd; wr_en = wr; addr = 4'(a); wr_data = wd;
        e = exp_byte(a);
        @(posedge clk);
        pop_req = wr && (a == 1) && wd[0];
        push_ok = p && ((model.size() < QDEPTH) || (pop_req && model.size() > 0));
        if (pop_req && model.size() > 0) void'(model.pop_front());
        if (push_ok) model.push_back(mk(seq));
        if (p && !push_ok) m_ovf = 1'b1;
        if (p) seq++;
        #1;
        push_en = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
        chk({"R2 irq/", why}, {7'b0, irq}, {7'b0, model.size() != 0});
        chk({"R9 overflow/", why}, {7'b0, overflow}, {7'b0, m_ovf});
        chk({"R12 rd_valid/", why}, {7'b0, rd_valid}, {7'b0, rd});
        if (rd) chk({tag_of(a), " offset/", why}, rd_data, e);
    endtask

    task automatic read_all(string why);
        for (int a = 0; a < 16; a++) step(0, 1, 0, a, 8'h00, why);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        push_en = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        model.delete();
        m_ovf = 1'b0;
        rst_n = 1'b1;
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        step(0, 1, 0, 0, 8'h00, "R1 reset status");
        read_all("R10 empty fields");
        // R2: pushes raise the interrupt
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 8'h00, "R2 push");
        read_all("R8 head stable");
        read_all("R8 head stable again");
        // R4: write with bit 0 clear
        step(0, 0, 1, 1, 8'hFE, "R4 zero bit");
        read_all("R4 no pop");
        // R12: writes elsewhere ignored
        step(0, 0, 1, 2, 8'hFF, "R12 write ro");
        step(0, 0, 1, 0, 8'hFF, "R12 write status");
        step(0, 0, 1, 9, 8'hFF, "R12 write unmapped");
        read_all("R12 after writes");
        // R4: real pop, then order check
        step(0, 0, 1, 1, 8'h01, "R4 pop");
        read_all("R8 next record");
        // R11: push and pop together
        step(1, 0, 1, 1, 8'h01, "R11 push+pop");
        read_all("R11 after push+pop");
        // R9: fill and overflow
        while (model.size() < QDEPTH) step(1, 0, 0, 0, 8'h00, "R9 fill");
        step(0, 1, 0, 0, 8'h00, "R3 full status");
        step(1, 0, 0, 0, 8'h00, "R9 drop");
        step(1, 1, 0, 7, 8'h00, "R9 drop again");
        read_all("R9 head kept");
        // R11: full with simultaneous pop
        step(1, 1, 1, 1, 8'h01, "R11 full push+pop");
        read_all("R11 full kept");
        // R8: drain, reading and popping in the same cycle
        while (model.size() > 0) begin
            step(0, 1, 1, 1, 8'h01, "R8 drain pop");
            step(0, 1, 0, 2, 8'h00, "R8 drain vf");
            step(0, 1, 0, 3, 8'h00, "R8 drain func");
            step(0, 1, 0, 6, 8'h00, "R8 drain tag");
            step(0, 1, 0, 7, 8'h00, "R8 drain taghi");
        end
        // R10: pop on empty
        step(0, 0, 1, 1, 8'h01, "R10 pop empty");
        read_all("R10 empty after pop");
        // R11: push+pop on empty keeps the push
        step(1, 0, 1, 1, 8'h01, "R11 empty push+pop");
        read_all("R11 one record");
        step(0, 0, 1, 1, 8'hFF, "R4 pop all-ones");
        step(0, 1, 0, 0, 8'h00, "R2 drained");
        // R1/R9: only reset clears overflow
        do_reset();
        step(0, 1, 0, 0, 8'h00, "R1 second reset");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule